// File: doc/BRIEF.md
# Vectored Interrupt Aggregator with Fast-Interrupt Routing

This block collects event pulses from thirteen on-chip interrupt sources and latches each one in a status register. It masks them with an enable register and merges them onto eight prioritized IRQ lines. Each line stands for one fixed vector address from 0xFFF8 to 0xFFFF. Three further device request lines (picture unit, sound unit, sound beat) feed lines IRQ0, IRQ1 and IRQ4 directly. A combinational priority encoder reports the lowest-numbered active line as a vector address.

A 3-bit selector can take one source group off its normal IRQ line and route it to a separate fast-interrupt (FIQ) output. Only one group can be routed at a time, and one code routes nothing. A wake mask register, with the same bit layout as status and enable, drives a wake request. This request does not depend on the enable bits. Software reaches the four registers over a simple bus: a 2-bit address, a write strobe and a read-data port that is always valid.

Top module: `vic_top`

## Requirements
- R1: After reset, the enable, status and wake registers are zero and the FIQ select reads 7. No IRQ line, FIQ, wake or vector-valid output is asserted, and the vector address is 0.
- R2: A 1 on `srcEvt[b]` sets status bit b at the next rising clock edge, whatever the enable bit is. The bit stays set until software clears it.
- R3: Register address 1 returns status on a read. A write to address 1 clears each status bit written as 1 and leaves the bits written as 0 unchanged. If an event arrives on a bit in the same cycle as a clear of that bit, the bit stays set.
- R4: Bit positions 2, 14 and 15 of the enable, status and wake registers are never stored and always read 0.
- R5: Source bits map to IRQ lines as follows: bits 13 and 8 to IRQ3; bits 12 and 9 to IRQ5; bits 11 and 10 to IRQ2; bits 6, 5 and 4 to IRQ6; bits 7, 3, 1 and 0 to IRQ7.
- R6: An IRQ line fed by the registers is high exactly when at least one of its sources has both its status bit and its enable bit (register address 0) set and is not routed to FIQ.
- R7: `vecValid` is high when any IRQ line is high. `vecAddr` is then 0xFFF8 plus the lowest-numbered high line; otherwise it is 0.
- R8: The FIQ select register sits at address 3 and stores bits 2:0; bits above 2 read 0. FIQ codes: 0 routes `devIrq[0]`, 1 routes `devIrq[1]`, 2 routes source bit 11, 3 routes bit 10, 4 routes bit 8, 5 routes bits 12 and 9, 6 routes bit 13, and 7 routes nothing. `fiqOut` is high when a routed device line is high, or when a routed source has both its status and enable bits set.
- R9: A source or device line routed to FIQ no longer drives its IRQ line. The other sources on that line still do.
- R10: `wakeOut` is high when any status bit is set whose wake-mask bit (register address 2) is also set, whether or not that source is enabled.
- R11: `regRdData` shows, without a clock cycle of delay, the register that `regAddr` selects.
- R12: `devIrq[0]`, `devIrq[1]` and `devIrq[2]` drive IRQ0, IRQ1 and IRQ4 directly, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select: 0 enable, 1 status, 2 wake mask, 3 FIQ select |
| regWr | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register |
| srcEvt | input | 16 | Source event pulses, one bit per source |
| devIrq | input | 3 | Device request levels for IRQ0, IRQ1, IRQ4 |
| irqOut | output | 8 | IRQ lines 0 to 7 |
| vecValid | output | 1 | Some IRQ line is active |
| vecAddr | output | 16 | Vector address of the highest-priority line |
| fiqOut | output | 1 | Fast interrupt request |
| wakeOut | output | 1 | Wake request |

## Verification
The assertions check several rules on every cycle. They check that events latch, that write-1 clears take effect and that clears lose to same-cycle events. They also check that unused bit positions stay zero, that the reported vector is the lowest active line and that code 7 never raises FIQ. Two things need the bench's scenarios with known register contents: the many-to-one grouping of sources onto specific lines, and the way routing a group to FIQ removes it from its line while leaving the other sources on that line alone. The wake path and the device pass-through lines are also shown only by directed scenarios.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int IRQ_N  = 8;
  localparam int IDX_W  = $clog2(IRQ_N);
  localparam int SEL_W  = 3;
  localparam int DEV_N  = 3;

  localparam logic [DATA_W-1:0] IMPL_MASK = 16'h3FFB;
  localparam logic [DATA_W-1:0] VEC_BASE  = 16'hFFF8;
  localparam logic [SEL_W-1:0]  FIQ_NONE  = 3'd7;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN   = 2'd0,
    REG_STAT = 2'd1,
    REG_WAKE = 2'd2,
    REG_FIQ  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrEn;
    logic    wrClr;
    logic    wrWake;
    logic    wrFiq;
    regSel_e rdSel;
  } strobe_t;

  // IRQ line that a source bit feeds; -1 for an unused position
  function automatic int lineOf(input int b);
    case (b)
      13, 8:       return 3;
      12, 9:       return 5;
      11, 10:      return 2;
      6, 5, 4:     return 6;
      7, 3, 1, 0:  return 7;
      default:     return -1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lineMask(input int l);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++)
      if (IMPL_MASK[b] && lineOf(b) == l) m[b] = 1'b1;
    return m;
  endfunction

  // IRQ line driven by each device request input
  function automatic int devLine(input int d);
    case (d)
      0:       return 0;
      1:       return 1;
      default: return 4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fiqMask(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd2:    return 16'h0800;
      3'd3:    return 16'h0400;
      3'd4:    return 16'h0100;
      3'd5:    return 16'h1200;
      3'd6:    return 16'h2000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output strobe_t           strb
);
  regSel_e sel;

  assign sel = regSel_e'(regAddr);

  always_comb begin
    strb        = '0;
    strb.rdSel  = sel;
    strb.wrEn   = regWr && (sel == REG_EN);
    strb.wrClr  = regWr && (sel == REG_STAT);
    strb.wrWake = regWr && (sel == REG_WAKE);
    strb.wrFiq  = regWr && (sel == REG_FIQ);
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] srcEvt,
  output logic [DATA_W-1:0] enableQ,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] wakeQ,
  output logic [SEL_W-1:0]  fiqSelQ,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] clrBits;
  logic [DATA_W-1:0] statusD;

  assign clrBits = strb.wrClr ? wrData : '0;
  // a same-cycle event is OR-ed in after the clear, so it wins
  assign statusD = ((statusQ & ~clrBits) | srcEvt) & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      statusQ <= '0;
      wakeQ   <= '0;
      fiqSelQ <= FIQ_NONE;
    end else begin
      statusQ <= statusD;
      if (strb.wrEn)   enableQ <= wrData & IMPL_MASK;
      if (strb.wrWake) wakeQ   <= wrData & IMPL_MASK;
      if (strb.wrFiq)  fiqSelQ <= wrData[SEL_W-1:0];
    end
  end

  always_comb begin
    case (strb.rdSel)
      REG_EN:   rdData = enableQ;
      REG_STAT: rdData = statusQ;
      REG_WAKE: rdData = wakeQ;
      default:  rdData = {{(DATA_W-SEL_W){1'b0}}, fiqSelQ};
    endcase
  end

  // R2
  src_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((srcEvt & IMPL_MASK) != '0) |=>
      ((statusQ & $past(srcEvt & IMPL_MASK)) == $past(srcEvt & IMPL_MASK)));

  // R3
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((statusQ & $past(wrData & ~srcEvt)) == '0));

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrClr |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R4
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ | enableQ | wakeQ) & ~IMPL_MASK) == '0);
endmodule

// File: rtl/vic_route.sv
module vic_route
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] enableQ,
  input  logic [DATA_W-1:0] statusQ,
  input  logic [DATA_W-1:0] wakeQ,
  input  logic [SEL_W-1:0]  fiqSelQ,
  input  logic [DEV_N-1:0]  devIrq,
  output logic [IRQ_N-1:0]  irqOut,
  output logic              vecValid,
  output logic [DATA_W-1:0] vecAddr,
  output logic              fiqOut,
  output logic              wakeOut
);
  logic [DATA_W-1:0] liveSrc;
  logic [DATA_W-1:0] routedMask;
  logic [DATA_W-1:0] irqSrc;
  logic [DEV_N-1:0]  devRouted;
  logic [IRQ_N-1:0]  devLines;
  logic [IDX_W-1:0]  topIdx;

  assign liveSrc    = statusQ & enableQ;
  assign routedMask = fiqMask(fiqSelQ);
  assign irqSrc     = liveSrc & ~routedMask;

  always_comb begin
    devRouted = '0;
    for (int d = 0; d < DEV_N; d++)
      devRouted[d] = (d < 2) && (fiqSelQ == SEL_W'(d));
  end

  always_comb begin
    devLines = '0;
    for (int d = 0; d < DEV_N; d++)
      devLines[devLine(d)] = devLines[devLine(d)] | (devIrq[d] & ~devRouted[d]);
  end

  for (genvar l = 0; l < IRQ_N; l++) begin : g_line
    localparam logic [DATA_W-1:0] LMASK = lineMask(l);
    assign irqOut[l] = (|(irqSrc & LMASK)) | devLines[l];
  end

  assign fiqOut  = (|(liveSrc & routedMask)) | (|(devIrq & devRouted));
  assign wakeOut = |(statusQ & wakeQ);

  // lowest line number has priority
  always_comb begin
    topIdx = '0;
    for (int i = IRQ_N - 1; i >= 0; i--)
      if (irqOut[i]) topIdx = IDX_W'(i);
  end

  assign vecValid = |irqOut;
  assign vecAddr  = vecValid ? (VEC_BASE + DATA_W'(topIdx)) : '0;

  // R7
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (irqOut[vecAddr[IDX_W-1:0]] &&
      ((irqOut & ((IRQ_N'(1) << vecAddr[IDX_W-1:0]) - IRQ_N'(1))) == '0)));

  // R7
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut == '0) |-> (!vecValid && vecAddr == '0));

  // R8
  fiq_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fiqSelQ == FIQ_NONE) |-> !fiqOut);

  // R9
  ppu_routed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fiqSelQ == '0) |-> !irqOut[0]);

  // R6
  line_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & 8'hEC) != '0) |-> (liveSrc != '0));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] srcEvt,
  input  logic [DEV_N-1:0]  devIrq,
  output logic [IRQ_N-1:0]  irqOut,
  output logic              vecValid,
  output logic [DATA_W-1:0] vecAddr,
  output logic              fiqOut,
  output logic              wakeOut
);
  strobe_t           strb;
  logic [DATA_W-1:0] enableQ;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] wakeQ;
  logic [SEL_W-1:0]  fiqSelQ;

  vic_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWr   (regWr),
    .strb    (strb)
  );

  vic_regs regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .srcEvt  (srcEvt),
    .enableQ (enableQ),
    .statusQ (statusQ),
    .wakeQ   (wakeQ),
    .fiqSelQ (fiqSelQ),
    .rdData  (regRdData)
  );

  vic_route route_i (
    .clk      (clk),
    .rstN     (rstN),
    .enableQ  (enableQ),
    .statusQ  (statusQ),
    .wakeQ    (wakeQ),
    .fiqSelQ  (fiqSelQ),
    .devIrq   (devIrq),
    .irqOut   (irqOut),
    .vecValid (vecValid),
    .vecAddr  (vecAddr),
    .fiqOut   (fiqOut),
    .wakeOut  (wakeOut)
  );
endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 15;

  // entry: {op(1: pulse), addr[1:0], data[15:0], expIrq[7:0], expVec{valid,idx}[3:0], expFiq}
  localparam logic [31:0] TBL [N_VEC] = '{
    {1'b0, 2'd0, 16'hFFFF, 8'h00, 4'h0, 1'b0},
    {1'b1, 2'd0, 16'h0001, 8'h80, 4'hF, 1'b0},
    {1'b1, 2'd0, 16'h0800, 8'h84, 4'hA, 1'b0},
    {1'b0, 2'd3, 16'h0002, 8'h80, 4'hF, 1'b1},
    {1'b1, 2'd0, 16'h0400, 8'h84, 4'hA, 1'b1},
    {1'b0, 2'd1, 16'h0800, 8'h84, 4'hA, 1'b0},
    {1'b0, 2'd3, 16'h0007, 8'h84, 4'hA, 1'b0},
    {1'b1, 2'd0, 16'h2000, 8'h8C, 4'hA, 1'b0},
    {1'b0, 2'd0, 16'h2000, 8'h08, 4'hB, 1'b0},
    {1'b0, 2'd3, 16'h0006, 8'h00, 4'h0, 1'b1},
    {1'b0, 2'd1, 16'hFFFF, 8'h00, 4'h0, 1'b0},
    {1'b0, 2'd0, 16'hFFFF, 8'h00, 4'h0, 1'b0},
    {1'b1, 2'd0, 16'h1270, 8'h60, 4'hD, 1'b0},
    {1'b0, 2'd3, 16'h0005, 8'h40, 4'hE, 1'b1},
    {1'b1, 2'd0, 16'h0100, 8'h48, 4'hB, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  regAddr;
  logic        regWr;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic [15:0] srcEvt;
  logic [2:0]  devIrq;
  logic [7:0]  irqOut;
  logic        vecValid;
  logic [15:0] vecAddr;
  logic        fiqOut;
  logic        wakeOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_top dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .srcEvt    (srcEvt),
    .devIrq    (devIrq),
    .irqOut    (irqOut),
    .vecValid  (vecValid),
    .vecAddr   (vecAddr),
    .fiqOut    (fiqOut),
    .wakeOut   (wakeOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWr = 1'b0; regAddr = '0; regWrData = '0; srcEvt = '0; devIrq = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // each op occupies one rising edge; outputs sampled at the following falling edge
  task automatic regWrite(input logic [1:0] a, input logic [15:0] d, input logic [15:0] ev);
    @(negedge clk);
    regAddr = a; regWr = 1'b1; regWrData = d; srcEvt = ev;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0; srcEvt = '0;
  endtask

  task automatic pulse(input logic [15:0] ev);
    @(negedge clk);
    srcEvt = ev;
    @(negedge clk);
    srcEvt = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    doReset();

    // R1 reset state
    @(negedge clk);
    check("R1 irq", {24'b0, irqOut}, 0);
    check("R1 fiq/wake/valid", {29'b0, fiqOut, wakeOut, vecValid}, 0);
    check("R1 vecAddr", {16'b0, vecAddr}, 0);
    readReg(2'd0, rv); check("R1 enable", {16'b0, rv}, 0);
    readReg(2'd1, rv); check("R1 status", {16'b0, rv}, 0);
    readReg(2'd2, rv); check("R1 wake", {16'b0, rv}, 0);
    readReg(2'd3, rv); check("R1 fiqSel", {16'b0, rv}, 32'd7);

    // table walk: R5 R6 R7 R8 R9
    for (int i = 0; i < N_VEC; i++) begin
      logic [31:0] e;
      e = TBL[i];
      if (e[31]) pulse(e[28:13]);
      else       regWrite(e[30:29], e[28:13], 16'h0);
      check($sformatf("R5/R6/R9 irq step %0d", i), {24'b0, irqOut}, {24'b0, e[12:5]});
      check($sformatf("R7 vec step %0d", i), {28'b0, vecValid, vecAddr[2:0]}, {28'b0, e[4:1]});
      if (e[4]) check($sformatf("R7 vecAddr step %0d", i), {16'b0, vecAddr}, {16'b0, 16'hFFF8 + {13'b0, e[3:1]}});
      check($sformatf("R8 fiq step %0d", i), {31'b0, fiqOut}, {31'b0, e[0]});
    end

    // R4 unused bits, R8/R11 select width
    doReset();
    regWrite(2'd0, 16'hFFFF, 16'h0);
    readReg(2'd0, rv); check("R4 enable unused", {16'b0, rv}, 32'h3FFB);
    regWrite(2'd2, 16'hFFFF, 16'h0);
    readReg(2'd2, rv); check("R4 wake unused", {16'b0, rv}, 32'h3FFB);
    regWrite(2'd3, 16'hFFFF, 16'h0);
    readReg(2'd3, rv); check("R11 fiqSel readback", {16'b0, rv}, 32'h0007);
    pulse(16'hC004);
    readReg(2'd1, rv); check("R4 status unused", {16'b0, rv}, 0);
    check("R4 no irq from unused", {24'b0, irqOut}, 0);
    regWrite(2'd2, 16'h0000, 16'h0);

    // R3 clear semantics
    pulse(16'h0008);
    readReg(2'd1, rv); check("R2 status latched", {16'b0, rv}, 32'h0008);
    regWrite(2'd1, 16'h0000, 16'h0);
    readReg(2'd1, rv); check("R3 zero write keeps", {16'b0, rv}, 32'h0008);
    regWrite(2'd1, 16'h0008, 16'h0008);
    readReg(2'd1, rv); check("R3 event beats clear", {16'b0, rv}, 32'h0008);
    regWrite(2'd1, 16'h0008, 16'h0);
    readReg(2'd1, rv); check("R3 clear", {16'b0, rv}, 0);

    // R10 wake independent of enable; R2 latch with enable off
    regWrite(2'd0, 16'h0000, 16'h0);
    pulse(16'h0008);
    readReg(2'd1, rv); check("R2 latch while disabled", {16'b0, rv}, 32'h0008);
    check("R10 wake masked off", {31'b0, wakeOut}, 0);
    check("R6 disabled no irq", {24'b0, irqOut}, 0);
    regWrite(2'd2, 16'h0008, 16'h0);
    check("R10 wake asserted", {31'b0, wakeOut}, 1);

    // R12 device lines and their FIQ routing
    regWrite(2'd2, 16'h0000, 16'h0);
    regWrite(2'd1, 16'hFFFF, 16'h0);
    @(negedge clk);
    devIrq = 3'b111;
    #1;
    check("R12 dev lines", {24'b0, irqOut}, 32'h13);
    check("R12 vec IRQ0", {16'b0, vecAddr}, 32'hFFF8);
    check("R8 fiq none", {31'b0, fiqOut}, 0);
    regWrite(2'd3, 16'h0000, 16'h0);
    check("R9 dev0 routed", {24'b0, irqOut}, 32'h12);
    check("R8 fiq dev0", {31'b0, fiqOut}, 1);
    check("R7 vec IRQ1", {16'b0, vecAddr}, 32'hFFF9);
    regWrite(2'd3, 16'h0001, 16'h0);
    check("R9 dev1 routed", {24'b0, irqOut}, 32'h11);
    check("R8 fiq dev1", {31'b0, fiqOut}, 1);
    regWrite(2'd3, 16'h0007, 16'h0);
    devIrq = 3'b100;
    #1;
    check("R12 beat line", {24'b0, irqOut}, 32'h10);
    check("R7 vec IRQ4", {16'b0, vecAddr}, 32'hFFFC);
    check("R8 fiq off", {31'b0, fiqOut}, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule